// File: doc/BRIEF.md
# Cascadable Nibble Magnitude Comparator

This block compares two unsigned operands one 4-bit slice at a time and reports on three separate result lines whether the first operand is greater than, equal to or less than the second. Each slice also takes three cascade lines. These carry the result of the slice below it. A slice uses them only when its own two nibbles match, so identical slices can be chained from the least significant nibble upward. The slice at the top of the chain gives the answer for the whole word.

The top level builds a chain of a parameterised number of slices, with two slices (an 8-bit word) by default. The cascade lines of the lowest slice are top-level inputs. For a plain compare they are driven with equal HIGH and greater and less LOW. A wider system can also feed them from another chain. All logic is combinational. The result follows the operands within the same cycle and holds no state.

Top module: `mag_cmp_chain`

## Requirements
- R1: When exactly one cascade input is HIGH, exactly one of `res_gt`, `res_eq`, `res_lt` is HIGH, for any operand values.
- R2: When `a_word` is greater than `b_word` as unsigned numbers, the outputs are gt=1, eq=0, lt=0, whatever the cascade inputs are.
- R3: When `a_word` is less than `b_word` as unsigned numbers, the outputs are gt=0, eq=0, lt=1, whatever the cascade inputs are.
- R4: When `a_word` equals `b_word`, each output copies its cascade input unchanged. This includes the invalid combinations with no line HIGH or with several lines HIGH.
- R5: Within a slice the decision follows the most significant bit position where the operands differ (bit 3 is the most significant). Lower bits do not affect it: 1000 against 0111 gives greater.
- R6: In the chain, slice k covers bits 4k+3 down to 4k. A difference in a higher slice overrides every lower slice. With the cascade inputs driven as equal, the chain result matches the unsigned compare of the whole words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_word | input | NIB_W*NUM_STAGES (8) | First unsigned operand |
| b_word | input | NIB_W*NUM_STAGES (8) | Second unsigned operand |
| casc_gt | input | 1 | Greater line coming from a lower chain; tie LOW when unused |
| casc_eq | input | 1 | Equal line coming from a lower chain; tie HIGH when unused |
| casc_lt | input | 1 | Less line coming from a lower chain; tie LOW when unused |
| res_gt | output | 1 | HIGH when a_word is greater |
| res_eq | output | 1 | HIGH when the words match and the cascade reports equal |
| res_lt | output | 1 | HIGH when a_word is less |

## Verification
The bench goes through every pair of nibble values for one slice, under all eight cascade patterns. A slice that let the cascade win over a local difference would pass the wrong result up the chain. A slice that cleaned up invalid cascade patterns would break the pass-through rule. On the 8-bit chain, the bench targets words that differ only in the LSB and a high nibble that disagrees with a low nibble, such as 0x10 against 0x0F and 0x80 against 0x7F. A wrong bit priority or a reversed chain order shows up there as an inverted answer. The all-zero and all-ones pairs catch a slice that never reports equal.

// File: rtl/cmp_pkg.sv
// Package: shared result type and constants for the nibble comparator.
// Assumes results are carried as three separate lines {gt, eq, lt}.
package cmp_pkg;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } cmp_flags_t;

    localparam cmp_flags_t FLAGS_GT = '{gt: 1'b1, eq: 1'b0, lt: 1'b0};
    localparam cmp_flags_t FLAGS_EQ = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
    localparam cmp_flags_t FLAGS_LT = '{gt: 1'b0, eq: 1'b0, lt: 1'b1};

endpackage

// File: rtl/nib_xnor_eq.sv
// Module: per-bit match detector. One XNOR per bit position, plus an
// all-bits-match flag. Assumes both operands have the same width.
module nib_xnor_eq #(
    parameter int W = 4
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] bit_same,
    output logic         all_same
);

    // One match line per bit position.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_same[i] = ~(op_a[i] ^ op_b[i]);
    end

    // The operands match only when every bit matches.
    assign all_same = &bit_same;

endmodule

// File: rtl/msb_diff_decider.sv
// Module: finds the most significant differing bit and reports whether
// operand A holds the 1 there. Assumes bit W-1 is the most significant.
// The output has no meaning when all bits match.
module msb_diff_decider #(
    parameter int W = 4
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] bit_same,
    output logic         a_wins
);

    logic [W-1:0] above_same;
    logic [W-1:0] win_here;

    // Prefix chain: position i is decisive only if every bit above it matches.
    assign above_same[W-1] = 1'b1;
    for (genvar i = W - 2; i >= 0; i--) begin : g_prefix
        assign above_same[i] = above_same[i+1] & bit_same[i+1];
    end

    // A wins at the first differing position where A holds the 1.
    for (genvar i = 0; i < W; i++) begin : g_win
        assign win_here[i] = above_same[i] & ~bit_same[i] & op_a[i];
    end

    assign a_wins = |win_here;

endmodule

// File: rtl/casc_merge.sv
// Module: chooses between the local compare result and the cascade input.
// When the local operands match, the cascade lines pass through unchanged,
// even if they are not one-hot.
module casc_merge
    import cmp_pkg::*;
(
    input  logic       local_same,
    input  logic       local_a_wins,
    input  cmp_flags_t casc_in,
    output cmp_flags_t res_out
);

    // Selects the cascade on a local match, otherwise the local decision.
    always_comb begin
        if (local_same) begin
            res_out = casc_in;
        end else if (local_a_wins) begin
            res_out = FLAGS_GT;
        end else begin
            res_out = FLAGS_LT;
        end
    end

endmodule

// File: rtl/mag_cmp_stage.sv
// Module: one comparator slice. Does the local nibble compare and
// resolves it against the cascade result from the slice below.
module mag_cmp_stage
    import cmp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  cmp_flags_t   casc_in,
    output cmp_flags_t   res_out
);

    logic [W-1:0] bit_same;
    logic         all_same;
    logic         a_wins;

    nib_xnor_eq #(.W(W)) u_eq (
        .op_a    (op_a),
        .op_b    (op_b),
        .bit_same(bit_same),
        .all_same(all_same)
    );

    msb_diff_decider #(.W(W)) u_dec (
        .op_a    (op_a),
        .bit_same(bit_same),
        .a_wins  (a_wins)
    );

    casc_merge u_merge (
        .local_same  (all_same),
        .local_a_wins(a_wins),
        .casc_in     (casc_in),
        .res_out     (res_out)
    );

endmodule

// File: rtl/mag_cmp_chain.sv
// Module: top level. Chains NUM_STAGES slices from the LSB upward. The
// external cascade lines feed slice 0, and the highest slice drives
// the result. Purely combinational.
module mag_cmp_chain
    import cmp_pkg::*;
#(
    parameter int NIB_W      = 4,
    parameter int NUM_STAGES = 2
) (
    input  logic [NIB_W*NUM_STAGES-1:0] a_word,
    input  logic [NIB_W*NUM_STAGES-1:0] b_word,
    input  logic                        casc_gt,
    input  logic                        casc_eq,
    input  logic                        casc_lt,
    output logic                        res_gt,
    output logic                        res_eq,
    output logic                        res_lt
);

    localparam int WORD_W = NIB_W * NUM_STAGES;

    cmp_flags_t link [NUM_STAGES+1];

    // The external cascade enters at the bottom of the chain.
    assign link[0] = '{gt: casc_gt, eq: casc_eq, lt: casc_lt};

    // One slice per nibble; each one passes its result upward.
    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        mag_cmp_stage #(.W(NIB_W)) u_stage (
            .op_a   (a_word[k*NIB_W +: NIB_W]),
            .op_b   (b_word[k*NIB_W +: NIB_W]),
            .casc_in(link[k]),
            .res_out(link[k+1])
        );
    end

    // The highest slice gives the result for the whole word.
    assign res_gt = link[NUM_STAGES].gt;
    assign res_eq = link[NUM_STAGES].eq;
    assign res_lt = link[NUM_STAGES].lt;

    if (WORD_W < 1) begin : g_bad_width
        initial $error("mag_cmp_chain: word width must be positive");
    end

endmodule

// File: rtl/mag_cmp_chain_chk.sv
// Checker: port-level rules for the comparator chain, bound to every
// instance of mag_cmp_chain. Immediate checks; stays quiet while inputs are unknown.
module mag_cmp_chain_chk #(
    parameter int WORD_W = 8
) (
    input logic [WORD_W-1:0] a_word,
    input logic [WORD_W-1:0] b_word,
    input logic              casc_gt,
    input logic              casc_eq,
    input logic              casc_lt,
    input logic              res_gt,
    input logic              res_eq,
    input logic              res_lt
);

    // Checks the result lines against the operands and the cascade lines.
    always_comb begin
        if (!$isunknown({a_word, b_word, casc_gt, casc_eq, casc_lt})) begin
            // R1: one-hot cascade in gives one-hot result out
            if ($onehot({casc_gt, casc_eq, casc_lt}))
                a_r1_onehot_result: assert ($onehot({res_gt, res_eq, res_lt}));
            // R2: a greater word wins over any cascade
            if (a_word > b_word)
                a_r2_greater_wins: assert ({res_gt, res_eq, res_lt} == 3'b100);
            // R3: a smaller word wins over any cascade
            if (a_word < b_word)
                a_r3_less_wins: assert ({res_gt, res_eq, res_lt} == 3'b001);
            // R4: equal words pass the cascade lines through
            if (a_word == b_word)
                a_r4_equal_passes: assert ({res_gt, res_eq, res_lt} ==
                                           {casc_gt, casc_eq, casc_lt});
        end
    end

endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.WORD_W(NIB_W*NUM_STAGES)) u_chk (
    .a_word (a_word),
    .b_word (b_word),
    .casc_gt(casc_gt),
    .casc_eq(casc_eq),
    .casc_lt(casc_lt),
    .res_gt (res_gt),
    .res_eq (res_eq),
    .res_lt (res_lt)
);

// File: tb/mag_cmp_chain_bench.sv
// Bench: a vector table on the two-slice chain, then exhaustive and
// invalid-cascade checks on a single slice, then random words.
module mag_cmp_chain_bench;

    logic clk;
    logic rst_n;
    int   n_checks;
    int   n_fails;
    bit   finished;

    logic [7:0] a8, b8;
    logic [2:0] c8;
    logic       g8, e8, l8;
    logic [3:0] a4, b4;
    logic [2:0] c4;
    logic       g4, e4, l4;

    // Drives the 250 MHz clock.
    initial clk = 1'b0;
    always #2 clk = ~clk;

    mag_cmp_chain #(.NIB_W(4), .NUM_STAGES(2)) u_mag_cmp_chain (
        .a_word(a8), .b_word(b8),
        .casc_gt(c8[2]), .casc_eq(c8[1]), .casc_lt(c8[0]),
        .res_gt(g8), .res_eq(e8), .res_lt(l8)
    );

    mag_cmp_chain #(.NIB_W(4), .NUM_STAGES(1)) u_mag_cmp_chain_nib (
        .a_word(a4), .b_word(b4),
        .casc_gt(c4[2]), .casc_eq(c4[1]), .casc_lt(c4[0]),
        .res_gt(g4), .res_eq(e4), .res_lt(l4)
    );

    // Vector layout: {a[7:0], b[7:0], cascade{gt,eq,lt}, expected{gt,eq,lt}}
    localparam int NVEC = 14;
    localparam logic [21:0] VEC [NVEC] = '{
        {8'h00, 8'h00, 3'b010, 3'b010},
        {8'hFF, 8'hFF, 3'b010, 3'b010},
        {8'hFF, 8'h00, 3'b010, 3'b100},
        {8'h00, 8'hFF, 3'b010, 3'b001},
        {8'h01, 8'h00, 3'b010, 3'b100},
        {8'h00, 8'h01, 3'b010, 3'b001},
        {8'h80, 8'h7F, 3'b010, 3'b100},
        {8'h7F, 8'h80, 3'b010, 3'b001},
        {8'h10, 8'h0F, 3'b010, 3'b100},
        {8'h3C, 8'h3C, 3'b100, 3'b100},
        {8'h3C, 8'h3C, 3'b001, 3'b001},
        {8'h5A, 8'h5B, 3'b100, 3'b001},
        {8'hA5, 8'hA5, 3'b000, 3'b000},
        {8'hA5, 8'hA5, 3'b101, 3'b101}
    };

    // Counts one check and reports a mismatch.
    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] ref_cmp(input int a, input int b, input logic [2:0] c);
        if (a > b) return 3'b100;
        if (a < b) return 3'b001;
        return c;
    endfunction

    // Main sequence: inputs driven after a rising edge, sampled at the falling edge.
    initial begin
        n_checks = 0; n_fails = 0; finished = 0;
        rst_n = 1'b0;
        a8 = '0; b8 = '0; c8 = 3'b010;
        a4 = '0; b4 = '0; c4 = 3'b010;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 initial zero words", {g8, e8, l8}, 3'b010);

        // R2 R3 R4 R5 R6: vector table on the 8-bit chain
        for (int i = 0; i < NVEC; i++) begin
            @(posedge clk);
            a8 = VEC[i][21:14]; b8 = VEC[i][13:6]; c8 = VEC[i][5:3];
            @(negedge clk);
            check("R6 table vector", {g8, e8, l8}, VEC[i][2:0]);
        end

        // R1 R2 R3 R4 R5: one slice, all operands, all cascade patterns
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                for (int c = 0; c < 8; c++) begin
                    @(posedge clk);
                    a4 = 4'(a); b4 = 4'(b); c4 = 3'(c);
                    @(negedge clk);
                    if (a > b)      check("R2 R5 slice greater", {g4, e4, l4}, 3'b100);
                    else if (a < b) check("R3 R5 slice less", {g4, e4, l4}, 3'b001);
                    else            check("R4 slice pass-through", {g4, e4, l4}, 3'(c));
                    if (c == 1 || c == 2 || c == 4)
                        check("R1 slice one-hot", {2'b00, $onehot({g4, e4, l4})}, 3'b001);
                end
            end
        end

        // R5: priority goes to bit 3
        @(posedge clk); a4 = 4'b1000; b4 = 4'b0111; c4 = 3'b001;
        @(negedge clk); check("R5 msb priority", {g4, e4, l4}, 3'b100);

        // R6: random words against the reference compare
        for (int n = 0; n < 2000; n++) begin
            @(posedge clk);
            a8 = 8'($urandom); b8 = 8'($urandom);
            if (n % 4 == 0) b8 = a8;
            if (n % 4 == 1) b8 = a8 ^ 8'h01;
            c8 = 3'b010;
            @(negedge clk);
            check("R6 random chain", {g8, e8, l8}, ref_cmp(int'(a8), int'(b8), c8));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        #1000000;
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule